// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Master Enable and Stack-Full Hold-Off

This block collects interrupt requests from five sources and hands at most one of them at a time to the instruction sequencer. The sources are:

- an external request pin, active low and asynchronous;
- overflow pulses from three 16-bit timers;
- an overflow pulse from one 8-bit timer.

Each source has a request flag and an enable bit. These sit in two byte-wide control registers, together with a single master enable. Software reads the registers through a combinational read port and writes them through a one-cycle write strobe.

A request is accepted when four things hold: the master enable is set, the source's flag is set, the source's enable is set, and the return stack is not full. On acceptance the block clears the master enable and the flag of the winning source. One clock later it raises a one-cycle vector request carrying the source number. Flags keep latching while the master enable is clear. A handler that wants to allow nesting sets the master enable again. When the sequencer reports a full stack, acceptance waits, and it resumes as soon as that indication drops. Saving processor status is left to software.

Top module: `ic_irq_ctrl`

## Requirements
- R1: After a synchronous reset, both control registers read 0x00 and `vec_req` is low.
- R2: A one-cycle high pulse on a timer overflow input sets that source's flag at the next clock edge, whatever the enable bits and the master enable hold. The flag then stays set until it is accepted or written to zero.
- R3: The external pin passes through two synchronizer flops. A high-to-low transition sets the external flag two clock edges after it is captured. A low-to-high transition, or a steady level, sets nothing.
- R4: A request is accepted when the master enable is set, some source has both its flag and its enable set, and `stack_full` is low. `vec_req` is then high for one cycle, in the cycle after acceptance. While `stack_full` is high nothing is accepted and the flags are kept, and acceptance happens in the first cycle in which `stack_full` is low again.
- R5: Priority is fixed by source number, and the lowest number wins: external = 0, 16-bit timers A, B and C = 1, 2 and 3, 8-bit timer = 4. `vec_id` carries the winner's number while `vec_req` is high.
- R6: Acceptance clears the master enable and the winning source's flag at the same clock edge. The other flags are unchanged.
- R7: While the master enable is clear, no request is accepted, but flags still latch. Writing the master enable back to 1 lets the next pending, enabled source be accepted in the following cycle, which allows nesting.
- R8: The register at address 0x0B holds the following fields:

  | Bit | Field |
  |-----|-------|
  | 0 | master enable |
  | 1–3 | enables for sources 0, 1, 2 |
  | 4–6 | flags for sources 0, 1, 2 |
  | 7 | reads 0 |

  The register at address 0x1E holds the following fields:

  | Bit | Field |
  |-----|-------|
  | 0–1 | enables for sources 3, 4 |
  | 2–3 | flags for sources 3, 4 |
  | 4–7 | read 0 |

  A write loads the fields of the addressed register. A hardware set of a flag in the same cycle wins over a written 0. Acceptance in the same cycle clears the master enable even if the write sets it.
- R9: A source whose enable bit is 0 is never accepted, even when its flag is set and the master enable is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Write strobe for the control registers |
| reg_waddr | input | 8 | Write address (0x0B or 0x1E) |
| reg_wdata | input | 8 | Write data |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data; 0 for other addresses |
| ext_irq_n | input | 1 | Asynchronous external request, falling edge active |
| t16_ovf | input | 3 | Overflow pulses of 16-bit timers A, B, C (bit i = source i+1) |
| t8_ovf | input | 1 | Overflow pulse of the 8-bit timer |
| stack_full | input | 1 | Return stack is full; withholds acceptance |
| vec_req | output | 1 | One-cycle vector request to the sequencer |
| vec_id | output | 3 | Number of the accepted source |

## Verification
A wrong flag or enable bit would be visible right away through the read port, and a priority error would show up as the wrong `vec_id` in the cycle after acceptance. A master enable that fails to clear would show as a second `vec_req` with no intervening write. A stack hold-off that is ignored would show as `vec_req` one cycle after `stack_full` was high. Because every flag and enable bit appears in one of the two readable registers, a corrupted bit shows up on the next read, within a single cycle. The bench compares both registers and the vector outputs against a model after every clock.

// File: rtl/ic_pkg.sv
package ic_pkg;

    localparam int NSRC = 5;
    localparam int ID_W = $clog2(NSRC);

    typedef enum logic [ID_W-1:0] {
        SRC_EXT  = 3'd0,
        SRC_T16A = 3'd1,
        SRC_T16B = 3'd2,
        SRC_T16C = 3'd3,
        SRC_T8   = 3'd4
    } src_id_t;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic     master;
        src_vec_t en;
        src_vec_t flag;
    } ctrl_state_t;

    typedef struct packed {
        logic            valid;
        logic [ID_W-1:0] id;
    } grant_t;

    // lowest-numbered set bit wins
    function automatic grant_t pick_first(input src_vec_t v);
        grant_t g;
        g.valid = 1'b0;
        g.id    = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                g.valid = 1'b1;
                g.id    = ID_W'(i);
            end
        end
        return g;
    endfunction

    // register at the lower address: master, enables 0..2, flags 0..2
    function automatic logic [7:0] pack_lo(input ctrl_state_t s);
        return {1'b0, s.flag[2:0], s.en[2:0], s.master};
    endfunction

    // register at the upper address: enables 3..4, flags 3..4
    function automatic logic [7:0] pack_hi(input ctrl_state_t s);
        return {4'b0000, s.flag[4:3], s.en[4:3]};
    endfunction

endpackage

// File: rtl/ic_edge_sync.sv
module ic_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic fall
);
    // sh[0..STAGES-1] synchronize, sh[STAGES] remembers the previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh[0] <= 1'b1;
        else     sh[0] <= async_n;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) sh[i] <= 1'b1;
            else     sh[i] <= sh[i-1];
        end
    end

    assign fall = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/ic_arbiter.sv
module ic_arbiter
    import ic_pkg::*;
(
    input  logic     master,
    input  src_vec_t pend,
    input  logic     stack_full,
    output grant_t   grant,
    output src_vec_t clr
);
    grant_t first;

    always_comb begin
        first       = pick_first(pend);
        grant.id    = first.id;
        grant.valid = first.valid & master & ~stack_full;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_clr
        assign clr[i] = grant.valid && (grant.id == ID_W'(i));
    end

endmodule

// File: rtl/ic_ctrl_regs.sv
module ic_ctrl_regs
    import ic_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  CTRL0_ADDR = 8'h0B,
    parameter logic [7:0]  CTRL1_ADDR = 8'h1E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  src_vec_t          set_vec,
    input  src_vec_t          clr_vec,
    input  logic              accept,
    output ctrl_state_t       state
);
    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(CTRL0_ADDR);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(CTRL1_ADDR);

    ctrl_state_t nxt;
    logic        hit0;
    logic        hit1;

    assign hit0 = wr && (waddr == A0);
    assign hit1 = wr && (waddr == A1);

    always_comb begin
        nxt.en     = state.en;
        nxt.flag   = state.flag & ~clr_vec;
        nxt.master = state.master;
        if (hit0) begin
            nxt.master    = wdata[0];
            nxt.en[2:0]   = wdata[3:1];
            nxt.flag[2:0] = wdata[6:4];
        end
        if (hit1) begin
            nxt.en[4:3]   = wdata[1:0];
            nxt.flag[4:3] = wdata[3:2];
        end
        nxt.flag = nxt.flag | set_vec;
        if (accept) nxt.master = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

endmodule

// File: rtl/ic_irq_ctrl.sv
module ic_irq_ctrl
    import ic_pkg::*;
#(
    parameter int         ADDR_W      = 8,
    parameter logic [7:0] CTRL0_ADDR  = 8'h0B,
    parameter logic [7:0] CTRL1_ADDR  = 8'h1E,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [7:0]        reg_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              ext_irq_n,
    input  logic [2:0]        t16_ovf,
    input  logic              t8_ovf,
    input  logic              stack_full,
    output logic              vec_req,
    output logic [ID_W-1:0]   vec_id
);
    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(CTRL0_ADDR);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(CTRL1_ADDR);

    logic        ext_fall;
    src_vec_t    set_vec;
    src_vec_t    clr_vec;
    src_vec_t    pend_vec;
    logic        master_q;
    ctrl_state_t state_q;
    grant_t      grant;

    ic_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (ext_irq_n),
        .fall    (ext_fall)
    );

    assign set_vec  = {t8_ovf, t16_ovf, ext_fall};
    assign pend_vec = state_q.flag & state_q.en;
    assign master_q = state_q.master;

    ic_arbiter u_arb (
        .master     (master_q),
        .pend       (pend_vec),
        .stack_full (stack_full),
        .grant      (grant),
        .clr        (clr_vec)
    );

    ic_ctrl_regs #(
        .ADDR_W     (ADDR_W),
        .CTRL0_ADDR (CTRL0_ADDR),
        .CTRL1_ADDR (CTRL1_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (reg_wr),
        .waddr   (reg_waddr),
        .wdata   (reg_wdata),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .accept  (grant.valid),
        .state   (state_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_req <= 1'b0;
            vec_id  <= '0;
        end else begin
            vec_req <= grant.valid;
            if (grant.valid) vec_id <= grant.id;
        end
    end

    always_comb begin
        if (rd_addr == A0)      rd_data = pack_lo(state_q);
        else if (rd_addr == A1) rd_data = pack_hi(state_q);
        else                    rd_data = 8'h00;
    end

endmodule

// File: rtl/ic_irq_ctrl_chk.sv
module ic_irq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       vec_req,
    input logic [2:0] vec_id,
    input logic       stack_full,
    input logic       master,
    input logic [4:0] pend
);
    p_ack_stack_free_r4: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> !$past(stack_full));

    p_ack_clears_master_r6: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> !master);

    p_ack_needs_master_r7: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> $past(master));

    p_ack_was_enabled_r9: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> ((($past(pend) >> vec_id) & 5'd1) != 5'd0));

    p_priority_r5: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (($past(pend) & ((5'd1 << vec_id) - 5'd1)) == 5'd0));

    p_id_range_r5: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> (vec_id < 3'd5));
endmodule

bind ic_irq_ctrl ic_irq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .vec_req    (vec_req),
    .vec_id     (vec_id),
    .stack_full (stack_full),
    .master     (master_q),
    .pend       (pend_vec)
);

// File: tb/tb_ic_irq_ctrl.sv
module tb_ic_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A0 = 8'h0B;
    localparam logic [7:0] A1 = 8'h1E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_waddr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       ext_irq_n = 1'b1;
    logic [2:0] t16_ovf = 3'b000;
    logic       t8_ovf = 1'b0;
    logic       stack_full = 1'b0;
    logic       vec_req;
    logic [2:0] vec_id;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // model state
    logic       m_master;
    logic [4:0] m_en;
    logic [4:0] m_flag;
    logic [2:0] m_sh;
    logic       e_ack;
    logic [2:0] e_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    ic_irq_ctrl dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_irq_n(ext_irq_n), .t16_ovf(t16_ovf), .t8_ovf(t8_ovf),
        .stack_full(stack_full), .vec_req(vec_req), .vec_id(vec_id)
    );

    function automatic logic [7:0] exp_lo();
        return {1'b0, m_flag[2:0], m_en[2:0], m_master};
    endfunction

    function automatic logic [7:0] exp_hi();
        return {4'b0000, m_flag[4:3], m_en[4:3]};
    endfunction

    function automatic logic [2:0] first_of(input logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_master = 1'b0; m_en = '0; m_flag = '0; m_sh = 3'b111;
        e_ack = 1'b0; e_id = '0;
    endtask

    // model of the next clock edge from the currently driven inputs
    task automatic model_step();
        logic [4:0] pend, setv, fl;
        logic acc;
        pend = m_flag & m_en;
        acc  = m_master && (pend != 0) && !stack_full;
        setv = {t8_ovf, t16_ovf, m_sh[2] & ~m_sh[1]};
        fl   = m_flag;
        if (acc) fl[first_of(pend)] = 1'b0;
        if (reg_wr && reg_waddr == A0) begin
            m_master = reg_wdata[0];
            m_en[2:0] = reg_wdata[3:1];
            fl[2:0] = reg_wdata[6:4];
        end
        if (reg_wr && reg_waddr == A1) begin
            m_en[4:3] = reg_wdata[1:0];
            fl[4:3] = reg_wdata[3:2];
        end
        m_flag = fl | setv;
        if (acc) m_master = 1'b0;
        m_sh  = {m_sh[1], m_sh[0], ext_irq_n};
        e_ack = acc;
        if (acc) e_id = first_of(pend);
    endtask

    task automatic check_all(input string tag);
        chk(tag, 32'(vec_req), 32'(e_ack));
        if (e_ack) chk(tag, 32'(vec_id), 32'(e_id));
        rd_addr = A0; #1;
        chk("R8", 32'(rd_data), 32'(exp_lo()));
        rd_addr = A1; #1;
        chk("R8", 32'(rd_data), 32'(exp_hi()));
    endtask

    task automatic cyc(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        reg_wr = 1'b0; t16_ovf = '0; t8_ovf = 1'b0;
    endtask

    task automatic wreg(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", 32'(vec_req), 32'd0);
        rd_addr = A0; #1; chk("R1", 32'(rd_data), 32'h00);
        rd_addr = A1; #1; chk("R1", 32'(rd_data), 32'h00);
        rst = 1'b0;
        cyc("R1");

        // R2: timer pulse latches with everything disabled
        t16_ovf = 3'b010; cyc("R2");
        t8_ovf = 1'b1; cyc("R2");
        repeat (2) cyc("R2");
        wreg(A0, 8'h00); cyc("R8");
        wreg(A1, 8'h00); cyc("R8");

        // R3: falling edge sets external flag, rising edge does not
        ext_irq_n = 1'b0; repeat (5) cyc("R3");
        wreg(A0, 8'h00); cyc("R3");
        ext_irq_n = 1'b1; repeat (5) cyc("R3");

        // R9: disabled source with master set never accepted
        t8_ovf = 1'b1; wreg(A0, 8'h01); cyc("R9");
        repeat (4) cyc("R9");
        wreg(A1, 8'h00); cyc("R9");

        // R5/R6/R7: all pending and enabled, priority walk via master re-arm
        t16_ovf = 3'b111; t8_ovf = 1'b1; cyc("R2");
        wreg(A1, 8'h03); cyc("R8");
        ext_irq_n = 1'b0; repeat (4) cyc("R3");
        ext_irq_n = 1'b1;
        wreg(A0, 8'h0F); cyc("R5");
        repeat (3) cyc("R7");
        for (int k = 0; k < 4; k++) begin
            wreg(A0, {1'b0, m_flag[2:0], m_en[2:0], 1'b1}); cyc("R6");
            cyc("R5");
            cyc("R7");
        end

        // R4: stack full withholds acceptance, resumes when it drops
        t16_ovf = 3'b100; cyc("R4");
        stack_full = 1'b1;
        wreg(A1, 8'h03); cyc("R4");
        wreg(A0, 8'h0F); cyc("R4");
        repeat (4) cyc("R4");
        stack_full = 1'b0; cyc("R4");
        repeat (2) cyc("R4");

        // R8: hardware set wins over written zero in same cycle
        t16_ovf = 3'b001; wreg(A0, 8'h00); cyc("R8");
        // R8: write setting master while accepting keeps master clear
        wreg(A0, 8'h23); cyc("R8");
        wreg(A0, 8'h03); cyc("R8");
        cyc("R8");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            stack_full = ($urandom % 4) == 0;
            t16_ovf    = 3'($urandom % 8) & {3{($urandom % 4) == 0}};
            t8_ovf     = ($urandom % 6) == 0;
            if (($urandom % 12) == 0) ext_irq_n = ~ext_irq_n;
            if (($urandom % 5) == 0) begin
                if ($urandom % 2) wreg(A0, 8'($urandom));
                else              wreg(A1, 8'($urandom));
            end
            cyc("R5");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule